// File: doc/BRIEF.md
# Link Control and Command Register Block

This block holds the control and status bits of one endpoint of a point-to-point serial link. Software reaches two 16-bit words through a simple register port with byte enables: a link control word at address 1 and a command word at address 0. Reads are combinational from the address. Writes take effect on the next rising clock edge. The block also takes single-cycle sideband events from the link layer: CRC error, CRC test complete, initialization complete and link failure detected. It drives level outputs back to the link layer: sync flood request, forced bad CRC, CRC test request, receive drop, NOP transmission, synchronization allowed and effective slave mode.

There are three reset domains. The cold reset is asynchronous and active low. Its release is synchronized to the clock inside the block, and it clears every bit. The warm and fabric resets are synchronous, active-high requests. A fabric reset does everything a warm reset does and also clears the end-of-chain bit. Some bits survive a warm reset, and some written values become effective only at the next warm or fabric reset.

Top module: `lcr_link_csr`

## Requirements
- R1: Bit 1 of the control word (sync flood enable) is read/write. When it is 1, a CRC error pulse sets `sync_flood` and control bit 4 (link failure) at the next edge. When it is 0, the same pulse changes neither.
- R2: Every CRC error pulse sets control bit 8 (CRC error logged), whatever bit 1 holds. Writing 1 to bit 8 with `reg_be[1]` high clears it.
- R3: Control bit 2 (CRC test) is set by writing 1 and is not cleared by writing 0. A `test_done` pulse clears it. `crc_test_req` follows the bit.
- R4: Control bit 3 is a plain read/write bit that drives `bad_crc_tx`.
- R5: Control bit 4 (link failure) is set by `fail_det` or by an escalated CRC error. It survives a warm reset. A failure seen by hardware takes effect at once. A software write changes the bit read back, but the effective flag (shown as `sync_allow` low) changes only at the next warm or fabric reset. While the effective flag is 1, bit 5 is never set.
- R6: Control bit 5 (initialization done) ignores writes. An `init_ok` pulse sets it when no failure is effective. A warm or fabric reset clears it.
- R7: Control bit 6 (end of chain) can be set by writing 1 and cannot be cleared by software. Only a fabric or cold reset clears it. While it is 1, `rx_drop` is 1 and `tx_nop` equals the inverse of control bit 7 (transmit off, read/write).
- R8: Command bit 10 (slave request) is read/write and is cleared only by a cold reset. `slave_mode` takes its value only at a warm or fabric reset.
- R9: Command bit 7 reads as `acc_chain`, bits 15:13 read 3'b001, and all other command bits read 0 and ignore writes.
- R10: `reg_be[0]` enables bits 7:0 and `reg_be[1]` enables bits 15:8. Control bits 0 and 15:9 read 0.
- R11: A cold reset clears everything, including the link failure and slave state. A warm reset clears bits 1, 2, 3, 5, 7 and 8 and `sync_flood`. A fabric reset also clears bit 6. Priority is cold over fabric over warm.
- R12: When a write and a hardware set or clear hit the same bit in one cycle, the hardware event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous cold reset, active low |
| warm_rst | input | 1 | Synchronous warm reset request |
| fabric_rst | input | 1 | Synchronous fabric reset request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 1 control, 0 command |
| reg_be | input | 2 | Byte enables |
| reg_wdata | input | 16 | Write data |
| acc_chain | input | 1 | Access comes from the chain side |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| crc_err | input | 1 | CRC error pulse |
| test_done | input | 1 | CRC test complete pulse |
| init_ok | input | 1 | Link initialization complete pulse |
| fail_det | input | 1 | Link failure detected pulse |
| sync_flood | output | 1 | Sync flood request |
| bad_crc_tx | output | 1 | Send bad CRCs |
| crc_test_req | output | 1 | CRC test request |
| rx_drop | output | 1 | Drop all received packets |
| tx_nop | output | 1 | Transmit NOPs with good CRC |
| sync_allow | output | 1 | Link synchronization allowed |
| slave_mode | output | 1 | Effective slave mode |

## Verification
A wrong internal state shows at the ports within one clock edge. Every stored bit is visible in `reg_rdata` or drives an output directly. The deferred values, the effective link failure and the slave mode, are harder. A wrong value there stays hidden until the next warm or fabric reset. After that reset it shows as `sync_allow` or `slave_mode` disagreeing with what was read back before the reset. It can also show earlier, as an `init_ok` pulse that sets or fails to set bit 5. The checks therefore compare the read-back value, the outputs and the response to `init_ok` after each reset request.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  localparam int DW = 16;
  // control word bit positions
  localparam int C_FLOOD = 1;
  localparam int C_TEST  = 2;
  localparam int C_BAD   = 3;
  localparam int C_FAIL  = 4;
  localparam int C_INIT  = 5;
  localparam int C_EOC   = 6;
  localparam int C_TXOFF = 7;
  localparam int C_CRCLG = 8;
  // command word bit positions
  localparam int K_CHAIN = 7;
  localparam int K_SLAVE = 10;
  localparam int K_CAP   = 13;
  localparam int CAP_W   = 3;
  localparam logic [CAP_W-1:0] CAP_VAL = 3'b001;
  localparam logic ADDR_CTL = 1'b1;
endpackage

// File: rtl/lcr_rst_sync.sv
module lcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/lcr_link_ctl.sv
module lcr_link_ctl
  import lcr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm,
  input  logic          fabric,
  input  logic          wr,
  input  logic [DW-1:0] wmask,
  input  logic [DW-1:0] wdata,
  input  logic          crc_err,
  input  logic          test_done,
  input  logic          init_ok,
  input  logic          fail_det,
  output logic [DW-1:0] rdata,
  output logic          sync_flood,
  output logic          bad_crc_tx,
  output logic          crc_test_req,
  output logic          rx_drop,
  output logic          tx_nop,
  output logic          sync_allow
);
  logic flood_q, test_q, bad_q, fail_q, feff_q, init_q, eoc_q, txoff_q, crclg_q, sf_q;
  logic flood_d, test_d, bad_d, fail_d, feff_d, init_d, eoc_d, txoff_d, crclg_d, sf_d;
  logic [DW-1:0] wen;
  logic          fail_now, upd;

  assign wen      = {DW{wr}} & wmask;
  assign fail_now = fail_det | (crc_err & flood_q);
  assign upd      = wr | warm | fabric | crc_err | test_done | init_ok | fail_det;

  always_comb begin
    flood_d = flood_q; test_d = test_q; bad_d = bad_q; fail_d = fail_q;
    feff_d  = feff_q;  init_d = init_q; eoc_d = eoc_q; txoff_d = txoff_q;
    crclg_d = crclg_q; sf_d   = sf_q;
    if (fabric || warm) begin
      flood_d = 1'b0; test_d = 1'b0; bad_d = 1'b0; init_d = 1'b0;
      txoff_d = 1'b0; crclg_d = 1'b0; sf_d = 1'b0;
      feff_d  = fail_q;
      if (fabric) eoc_d = 1'b0;
    end else begin
      // software first, hardware events override below
      if (wen[C_FLOOD]) flood_d = wdata[C_FLOOD];
      if (wen[C_BAD])   bad_d   = wdata[C_BAD];
      if (wen[C_TXOFF]) txoff_d = wdata[C_TXOFF];
      if (wen[C_FAIL])  fail_d  = wdata[C_FAIL];
      if (wen[C_TEST]  && wdata[C_TEST])  test_d  = 1'b1;
      if (wen[C_EOC]   && wdata[C_EOC])   eoc_d   = 1'b1;
      if (wen[C_CRCLG] && wdata[C_CRCLG]) crclg_d = 1'b0;
      if (test_done) test_d  = 1'b0;
      if (crc_err)   crclg_d = 1'b1;
      if (crc_err && flood_q) sf_d = 1'b1;
      if (fail_now) begin
        fail_d = 1'b1; feff_d = 1'b1; init_d = 1'b0;
      end else if (init_ok && !feff_q) begin
        init_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flood_q <= 1'b0; test_q <= 1'b0; bad_q <= 1'b0; fail_q <= 1'b0;
      feff_q  <= 1'b0; init_q <= 1'b0; eoc_q <= 1'b0; txoff_q <= 1'b0;
      crclg_q <= 1'b0; sf_q   <= 1'b0;
    end else if (upd) begin
      flood_q <= flood_d; test_q <= test_d; bad_q <= bad_d; fail_q <= fail_d;
      feff_q  <= feff_d;  init_q <= init_d; eoc_q <= eoc_d; txoff_q <= txoff_d;
      crclg_q <= crclg_d; sf_q   <= sf_d;
    end
  end

  always_comb begin
    rdata          = '0;
    rdata[C_FLOOD] = flood_q;
    rdata[C_TEST]  = test_q;
    rdata[C_BAD]   = bad_q;
    rdata[C_FAIL]  = fail_q;
    rdata[C_INIT]  = init_q;
    rdata[C_EOC]   = eoc_q;
    rdata[C_TXOFF] = txoff_q;
    rdata[C_CRCLG] = crclg_q;
  end

  assign sync_flood   = sf_q;
  assign bad_crc_tx   = bad_q;
  assign crc_test_req = test_q;
  assign rx_drop      = eoc_q;
  assign tx_nop       = eoc_q & ~txoff_q;
  assign sync_allow   = ~feff_q;

  p_flood_escalate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && flood_q && !warm && !fabric) |=> (sync_flood && fail_q));
  p_crc_logged_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !warm && !fabric) |=> crclg_q);
  p_test_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |=> !crc_test_req);
  p_init_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_allow |-> !init_q);
  p_eoc_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_q && !fabric) |=> eoc_q);
  p_fail_survives_warm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && warm && !fabric) |=> (fail_q && !sync_allow));
endmodule

// File: rtl/lcr_cmd.sv
module lcr_cmd
  import lcr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm,
  input  logic          fabric,
  input  logic          wr,
  input  logic [DW-1:0] wmask,
  input  logic [DW-1:0] wdata,
  input  logic          acc_chain,
  output logic [DW-1:0] rdata,
  output logic          slave_mode
);
  logic pend_q, pend_d, eff_q, eff_d, upd;

  assign upd = wr | warm | fabric;

  always_comb begin
    pend_d = pend_q;
    eff_d  = eff_q;
    if (warm || fabric)              eff_d  = pend_q;
    else if (wr && wmask[K_SLAVE])   pend_d = wdata[K_SLAVE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      eff_q  <= 1'b0;
    end else if (upd) begin
      pend_q <= pend_d;
      eff_q  <= eff_d;
    end
  end

  always_comb begin
    rdata                  = '0;
    rdata[K_CHAIN]         = acc_chain;
    rdata[K_SLAVE]         = pend_q;
    rdata[K_CAP +: CAP_W]  = CAP_VAL;
  end

  assign slave_mode = eff_q;

  p_slave_deferred_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!warm && !fabric) |=> $stable(slave_mode));
  p_slave_applied_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm || fabric) |=> (slave_mode == $past(pend_q)));
endmodule

// File: rtl/lcr_link_csr.sv
module lcr_link_csr
  import lcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          cold_rst_n,
  input  logic          warm_rst,
  input  logic          fabric_rst,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [1:0]    reg_be,
  input  logic [DW-1:0] reg_wdata,
  input  logic          acc_chain,
  output logic [DW-1:0] reg_rdata,
  input  logic          crc_err,
  input  logic          test_done,
  input  logic          init_ok,
  input  logic          fail_det,
  output logic          sync_flood,
  output logic          bad_crc_tx,
  output logic          crc_test_req,
  output logic          rx_drop,
  output logic          tx_nop,
  output logic          sync_allow,
  output logic          slave_mode
);
  localparam int BYTES = DW / 8;

  logic          rst_n;
  logic [DW-1:0] wmask, ctl_rd, cmd_rd;
  logic          ctl_wr, cmd_wr;

  lcr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(cold_rst_n), .rst_n(rst_n));

  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    assign wmask[b*8 +: 8] = {8{reg_be[b]}};
  end

  assign ctl_wr = reg_wr & (reg_addr == ADDR_CTL);
  assign cmd_wr = reg_wr & (reg_addr != ADDR_CTL);

  lcr_link_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .warm(warm_rst), .fabric(fabric_rst),
    .wr(ctl_wr), .wmask(wmask), .wdata(reg_wdata),
    .crc_err(crc_err), .test_done(test_done), .init_ok(init_ok), .fail_det(fail_det),
    .rdata(ctl_rd), .sync_flood(sync_flood), .bad_crc_tx(bad_crc_tx),
    .crc_test_req(crc_test_req), .rx_drop(rx_drop), .tx_nop(tx_nop),
    .sync_allow(sync_allow));

  lcr_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .warm(warm_rst), .fabric(fabric_rst),
    .wr(cmd_wr), .wmask(wmask), .wdata(reg_wdata), .acc_chain(acc_chain),
    .rdata(cmd_rd), .slave_mode(slave_mode));

  assign reg_rdata = (reg_addr == ADDR_CTL) ? ctl_rd : cmd_rd;

  p_eoc_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_drop |-> !tx_nop);
  p_cold_clears_r11: assert property (@(posedge clk)
    !rst_n |-> (!slave_mode && sync_allow && !sync_flood && !rx_drop));
endmodule

// File: tb/test_lcr_link_csr.sv
module test_lcr_link_csr;
  logic        clk = 1'b0;
  logic        cold_rst_n, warm_rst, fabric_rst, reg_wr, reg_addr, acc_chain;
  logic [1:0]  reg_be;
  logic [15:0] reg_wdata, reg_rdata;
  logic        crc_err, test_done, init_ok, fail_det;
  logic        sync_flood, bad_crc_tx, crc_test_req, rx_drop, tx_nop, sync_allow, slave_mode;
  int          total = 0, bad = 0;
  bit          wd_hit = 1'b0;

  always #5 clk = ~clk;

  lcr_link_csr i_lcr_link_csr (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst(warm_rst), .fabric_rst(fabric_rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .acc_chain(acc_chain), .reg_rdata(reg_rdata),
    .crc_err(crc_err), .test_done(test_done), .init_ok(init_ok), .fail_det(fail_det),
    .sync_flood(sync_flood), .bad_crc_tx(bad_crc_tx), .crc_test_req(crc_test_req),
    .rx_drop(rx_drop), .tx_nop(tx_nop), .sync_allow(sync_allow), .slave_mode(slave_mode));

  // ev: [5]fabric [4]warm [3]fail_det [2]init_ok [1]test_done [0]crc_err
  // outs: [6]slave [5]sync_allow [4]rx_drop [3]tx_nop [2]test_req [1]bad_crc [0]sync_flood
  typedef struct packed {
    logic [7:0]  req;
    logic        wr;
    logic        adr;
    logic [1:0]  be;
    logic [15:0] wd;
    logic [5:0]  ev;
    logic [15:0] ctl;
    logic [6:0]  outs;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VT [NV] = '{
    '{8'd1,  1'b1, 1'b1, 2'b01, 16'h0002, 6'h00, 16'h0002, 7'h20}, // R1 enable
    '{8'd1,  1'b0, 1'b1, 2'b00, 16'h0000, 6'h01, 16'h0112, 7'h01}, // R1 escalation
    '{8'd5,  1'b0, 1'b1, 2'b00, 16'h0000, 6'h04, 16'h0112, 7'h01}, // R5 init blocked
    '{8'd11, 1'b0, 1'b1, 2'b00, 16'h0000, 6'h10, 16'h0010, 7'h00}, // R11 warm
    '{8'd5,  1'b0, 1'b1, 2'b00, 16'h0000, 6'h04, 16'h0010, 7'h00}, // R5
    '{8'd5,  1'b1, 1'b1, 2'b01, 16'h0000, 6'h00, 16'h0000, 7'h00}, // R5 sw clear
    '{8'd5,  1'b0, 1'b1, 2'b00, 16'h0000, 6'h04, 16'h0000, 7'h00}, // R5 deferred
    '{8'd5,  1'b0, 1'b1, 2'b00, 16'h0000, 6'h10, 16'h0000, 7'h20}, // R5 applied
    '{8'd6,  1'b0, 1'b1, 2'b00, 16'h0000, 6'h04, 16'h0020, 7'h20}, // R6 init set
    '{8'd2,  1'b0, 1'b1, 2'b00, 16'h0000, 6'h01, 16'h0120, 7'h20}, // R2 log only
    '{8'd2,  1'b1, 1'b1, 2'b10, 16'h0100, 6'h00, 16'h0020, 7'h20}, // R2 w1c
    '{8'd3,  1'b1, 1'b1, 2'b01, 16'h0004, 6'h00, 16'h0024, 7'h24}, // R3 start
    '{8'd3,  1'b1, 1'b1, 2'b01, 16'h0000, 6'h00, 16'h0024, 7'h24}, // R3 no sw clear
    '{8'd3,  1'b0, 1'b1, 2'b00, 16'h0000, 6'h02, 16'h0020, 7'h20}, // R3 done
    '{8'd12, 1'b1, 1'b1, 2'b01, 16'h0004, 6'h02, 16'h0020, 7'h20}, // R12 test
    '{8'd4,  1'b1, 1'b1, 2'b01, 16'h0008, 6'h00, 16'h0028, 7'h22}, // R4
    '{8'd7,  1'b1, 1'b1, 2'b01, 16'h00C8, 6'h00, 16'h00E8, 7'h32}, // R7 eoc txoff
    '{8'd7,  1'b1, 1'b1, 2'b01, 16'h0048, 6'h00, 16'h0068, 7'h3A}, // R7 nop
    '{8'd7,  1'b1, 1'b1, 2'b01, 16'h0000, 6'h00, 16'h0060, 7'h38}, // R7 no sw clear
    '{8'd11, 1'b0, 1'b1, 2'b00, 16'h0000, 6'h10, 16'h0040, 7'h38}, // R11 warm keeps eoc
    '{8'd11, 1'b0, 1'b1, 2'b00, 16'h0000, 6'h20, 16'h0000, 7'h20}, // R11 fabric
    '{8'd10, 1'b1, 1'b1, 2'b10, 16'h0004, 6'h00, 16'h0000, 7'h20}, // R10 byte enable
    '{8'd12, 1'b1, 1'b1, 2'b01, 16'h0000, 6'h08, 16'h0010, 7'h00}, // R12 fail wins
    '{8'd5,  1'b0, 1'b1, 2'b00, 16'h0000, 6'h10, 16'h0010, 7'h00}, // R5 sticky
    '{8'd8,  1'b1, 1'b0, 2'b11, 16'hFFFF, 6'h00, 16'h0010, 7'h00}, // R8 pending
    '{8'd8,  1'b0, 1'b1, 2'b00, 16'h0000, 6'h10, 16'h0010, 7'h40}, // R8 applied
    '{8'd2,  1'b0, 1'b1, 2'b00, 16'h0000, 6'h01, 16'h0110, 7'h40}  // R2 flood off
  };

  function automatic logic [6:0] outs_now();
    return {slave_mode, sync_allow, rx_drop, tx_nop, crc_test_req, bad_crc_tx, sync_flood};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 1'b0; reg_addr = 1'b1; reg_be = 2'b00; reg_wdata = '0;
    crc_err = 1'b0; test_done = 1'b0; init_ok = 1'b0; fail_det = 1'b0;
    warm_rst = 1'b0; fabric_rst = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); idle(); #1;
  endtask

  task automatic cold();
    cold_rst_n = 1'b0; idle();
    repeat (2) @(negedge clk);
    cold_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    #200000;
    wd_hit = 1'b1;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    acc_chain = 1'b0;
    cold();
    // R11 reset state
    chk("R11 ctl", reg_rdata, 16'h0000);
    chk("R11 outs", {9'd0, outs_now()}, 16'h0020);
    reg_addr = 1'b0; #1;
    chk("R9 cmd reset", reg_rdata, 16'h2000);
    reg_addr = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_wr = VT[i].wr; reg_addr = VT[i].adr; reg_be = VT[i].be; reg_wdata = VT[i].wd;
      {fabric_rst, warm_rst, fail_det, init_ok, test_done, crc_err} = VT[i].ev;
      tick();
      chk($sformatf("R%0d ctl v%0d", VT[i].req, i), reg_rdata, VT[i].ctl);
      chk($sformatf("R%0d outs v%0d", VT[i].req, i), {9'd0, outs_now()}, {9'd0, VT[i].outs});
    end

    // R9 command word read from both sides
    reg_addr = 1'b0; #1;
    chk("R9 cmd bus side", reg_rdata, 16'h2400);
    acc_chain = 1'b1; #1;
    chk("R9 cmd chain side", reg_rdata, 16'h2480);
    acc_chain = 1'b0;

    // R8 pending survives warm; cleared only by cold
    @(negedge clk); warm_rst = 1'b1; tick();
    reg_addr = 1'b0; #1;
    chk("R8 pend after warm", reg_rdata, 16'h2400);

    // R11 cold clears sticky failure and slave state
    cold();
    chk("R11 cold ctl", reg_rdata, 16'h0000);
    chk("R11 cold outs", {9'd0, outs_now()}, 16'h0020);
    reg_addr = 1'b0; #1;
    chk("R8 cold cmd", reg_rdata, 16'h2000);

    // R11 fabric wins over warm: eoc cleared
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_be = 2'b01; reg_wdata = 16'h0040;
    tick();
    chk("R7 eoc set", reg_rdata, 16'h0040);
    @(negedge clk); warm_rst = 1'b1; fabric_rst = 1'b1; tick();
    chk("R11 fabric over warm", reg_rdata, 16'h0000);

    // R10 reserved control bits ignore writes
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_be = 2'b11; reg_wdata = 16'hFE01;
    tick();
    chk("R10 reserved", reg_rdata, 16'h0000);

    // R6 init done ignores writes
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_be = 2'b01; reg_wdata = 16'h0020;
    tick();
    chk("R6 write ignored", reg_rdata, 16'h0000);

    if (!wd_hit) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule